// File: doc/BRIEF.md
# Branch Trace Ring Recorder

This block keeps a short running history of the control-flow transfers a processor core takes: taken branches, interrupts and exceptions. The pipeline presents each transfer as one valid-qualified event carrying the address the transfer left from and the address it landed on. The two addresses are packed into one entry of an eight-slot circular store. A write pointer selects the slot for the next event and wraps, so the newest event always replaces the oldest one.

Software turns recording on and off through a one-bit enable in a control register. When the core raises a debug exception, capture freezes. The stored history then describes the transfers that led up to the exception. Software clears the freeze by writing the enable bit low and then high again, and the stored entries survive this. A registered read port returns any slot one cycle after its index is presented, and the pointer is visible at all times.

Capture is managed by a three-state machine:
- `S_OFF` means recording is disabled.
- `S_REC` means events are being stored.
- `S_HOLD` means recording is enabled but frozen.

The machine has these transitions:
- `S_OFF` goes to `S_REC` on a control write of 1.
- `S_REC` goes to `S_HOLD` when `dbg_exc` is high and no control write occurs.
- `S_REC` goes to `S_OFF` on a control write of 0.
- `S_HOLD` goes to `S_OFF` on a control write of 0.
- A control write of 1 leaves `S_REC` and `S_HOLD` where they are.

Top module: `branch_trace_ring`

## Requirements
- R1: After reset the pointer `tos` is 0, every slot reads as all zeros, and recording is disabled.
- R2: An event is stored only while recording is enabled and not frozen. While disabled, `ev_valid` and `dbg_exc` change neither the slots nor `tos`.
- R3: `tos` is a 3-bit index of the slot the next event will be written to. Each stored event is written at `tos`, and `tos` then advances by one modulo 8, so the ninth event overwrites slot 0.
- R4: A stored entry holds the source address in bits 31:0 and the destination address in bits 63:32.
- R5: A `dbg_exc` pulse while recording freezes capture. Later events change neither the slots nor `tos`.
- R6: If an event and `dbg_exc` arrive in the same cycle while recording, the event is still stored. The freeze takes effect from the next cycle.
- R7: Writing the enable bit as 1 while it is already 1 does not clear a freeze. Writing 0 and then 1 restarts recording, and the slots stored before the freeze keep their contents.
- R8: `rd_data` shows, one cycle after `rd_idx` is presented, the slot's content as it stood before that same clock edge. An event written to that slot in that cycle is not yet visible.
- R9: A control write takes effect from the next cycle and has priority over `dbg_exc` in the same cycle. An event arriving with the control write is judged by the state before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 1 | Enable value written with `ctl_wr` |
| ev_valid | input | 1 | A transfer event is present this cycle |
| ev_from | input | 32 | Source linear address of the event |
| ev_to | input | 32 | Destination linear address of the event |
| dbg_exc | input | 1 | A debug exception is raised this cycle |
| rd_idx | input | 3 | Slot index to read |
| rd_data | output | 64 | Registered content of the addressed slot |
| tos | output | 3 | Slot index the next event goes to |

## Verification
The bench aims at the wrap from slot 7 back to slot 0. A pointer that fails to wrap there, or that stops at 7, would place the ninth event in the wrong slot.

It presents an event together with a debug exception, where a design that freezes too early would drop the event. It also presents an event together with a disabling control write, where a design that applies the write at once would lose the event.

It rewrites the enable bit as 1 while frozen and then sequences it 0 then 1. This exposes a design that unfreezes on any write, or one that wipes the history when recording restarts.

Finally, it reads a slot in the same cycle that slot is being written, to catch a read port that forwards the new data.

// File: rtl/btr_pkg.sv
package btr_pkg;

    typedef enum logic [1:0] {
        S_OFF  = 2'd0,
        S_REC  = 2'd1,
        S_HOLD = 2'd2
    } cap_state_t;

endpackage

// File: rtl/btr_ctrl.sv
module btr_ctrl
    import btr_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_wdata,
    input  logic             ev_valid,
    input  logic             dbg_exc,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_ptr
);

    cap_state_t state_q, state_d;
    logic [PTR_W-1:0] ptr_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF: begin
                if (ctl_wr && ctl_wdata) state_d = S_REC;
            end
            S_REC: begin
                if (ctl_wr)       state_d = ctl_wdata ? S_REC : S_OFF;
                else if (dbg_exc) state_d = S_HOLD;
            end
            S_HOLD: begin
                if (ctl_wr && !ctl_wdata) state_d = S_OFF;
            end
            default: state_d = S_OFF;
        endcase
    end

    // outputs
    always_comb begin
        wr_en = 1'b0;
        unique case (state_q)
            S_REC:   wr_en = ev_valid;
            S_OFF,
            S_HOLD:  wr_en = 1'b0;
            default: wr_en = 1'b0;
        endcase
    end

    // write pointer, wraps modulo DEPTH
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (wr_en) begin
            if (ptr_q == PTR_W'(DEPTH - 1)) ptr_q <= '0;
            else                            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign wr_ptr = ptr_q;

    a_r2_idle_ptr_still: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_valid) |=> $stable(ptr_q));

    a_r5_hold_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD && !ctl_wr) |=> (state_q == S_HOLD && $stable(ptr_q)));

    a_r6_event_then_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_REC && ev_valid && dbg_exc && !ctl_wr)
        |=> (state_q == S_HOLD && ptr_q != $past(ptr_q)));

    a_r9_off_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_wdata) |=> (state_q == S_OFF));

endmodule

// File: rtl/btr_store.sv
module btr_store #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int ENT_W = 2 * ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_from,
    input  logic [ADDR_W-1:0] wr_to,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [ENT_W-1:0]  rd_data
);

    logic [ENT_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (wr_en && wr_idx == PTR_W'(g))
                slot_q[g] <= {wr_to, wr_from};
        end

        a_r4_slot_packing: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == PTR_W'(g))
            |=> (slot_q[g][ADDR_W-1:0] == $past(wr_from)
                 && slot_q[g][ENT_W-1:ADDR_W] == $past(wr_to)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= slot_q[rd_idx];
    end

endmodule

// File: rtl/branch_trace_ring.sv
module branch_trace_ring #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_wr,
    input  logic                ctl_wdata,
    input  logic                ev_valid,
    input  logic [ADDR_W-1:0]   ev_from,
    input  logic [ADDR_W-1:0]   ev_to,
    input  logic                dbg_exc,
    input  logic [PTR_W-1:0]    rd_idx,
    output logic [2*ADDR_W-1:0] rd_data,
    output logic [PTR_W-1:0]    tos
);

    logic             wr_en;
    logic [PTR_W-1:0] wr_ptr;

    btr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .ev_valid  (ev_valid),
        .dbg_exc   (dbg_exc),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr)
    );

    btr_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_ptr),
        .wr_from (ev_from),
        .wr_to   (ev_to),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    assign tos = wr_ptr;

    a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tos == PTR_W'($past(tos) + 1'b1)));

endmodule

// File: tb/branch_trace_ring_bench.sv
module branch_trace_ring_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0, ctl_wdata = 1'b0;
    logic        ev_valid = 1'b0, dbg_exc = 1'b0;
    logic [31:0] ev_from = '0, ev_to = '0;
    logic [2:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic [2:0]  tos;

    int n_chk = 0, n_fail = 0, cyc = 0;
    string phase = "R1";
    bit done = 1'b0;

    // behavioural reference
    logic [63:0] m_mem [8];
    int          m_tos = 0;
    int          m_st  = 0;   // 0 off, 1 recording, 2 frozen
    logic [63:0] m_rd  = '0;

    always #2 clk = ~clk;   // 250 MHz

    branch_trace_ring u_branch_trace_ring (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ev_valid(ev_valid), .ev_from(ev_from), .ev_to(ev_to),
        .dbg_exc(dbg_exc), .rd_idx(rd_idx), .rd_data(rd_data), .tos(tos)
    );

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_mem[i] = '0;
            m_tos = 0; m_st = 0; m_rd = '0;
        end else begin
            m_rd = m_mem[rd_idx];
            if (m_st == 1 && ev_valid) begin
                m_mem[m_tos] = {ev_to, ev_from};
                m_tos = (m_tos + 1) % 8;
            end
            if (ctl_wr) m_st = ctl_wdata ? ((m_st == 0) ? 1 : m_st) : 0;
            else if (m_st == 1 && dbg_exc) m_st = 2;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // compare against the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({phase, " R8 rd_data"}, rd_data, m_rd);
            chk({phase, " R3 tos"}, {61'd0, tos}, 64'(m_tos));
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        ctl_wr = 0; ev_valid = 0; dbg_exc = 0;
    endtask

    task automatic ev(input int k);
        ev_valid = 1; ev_from = 32'h1000_0000 + k; ev_to = 32'h2000_0000 + k;
        step(); idle();
    endtask

    task automatic ctl(input logic v);
        ctl_wr = 1; ctl_wdata = v; step(); idle();
    endtask

    task automatic rd(input int idx, input string req, input logic [63:0] exp);
        rd_idx = 3'(idx); step();
        chk(req, rd_data, exp);
    endtask

    function automatic logic [63:0] ent(input int k);
        return {32'h2000_0000 + 32'(k), 32'h1000_0000 + 32'(k)};
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        step();
        phase = "R1";
        chk("R1 tos after reset", {61'd0, tos}, 64'd0);
        for (int i = 0; i < 8; i++) rd(i, "R1 slot clear", 64'd0);

        phase = "R2";
        ev(90); ev(91);
        dbg_exc = 1; step(); idle();
        chk("R2 tos while disabled", {61'd0, tos}, 64'd0);
        rd(0, "R2 slot untouched", 64'd0);

        phase = "R4";
        ctl(1);
        ev(1); ev(2); ev(3);
        chk("R3 tos after three", {61'd0, tos}, 64'd3);
        rd(1, "R4 packing", {32'h2000_0002, 32'h1000_0002});

        phase = "R3";
        for (int k = 4; k <= 10; k++) ev(k);
        chk("R3 tos wrapped", {61'd0, tos}, 64'd2);
        rd(0, "R3 overwrite oldest", ent(9));
        rd(2, "R3 slot2 kept", ent(3));

        phase = "R9";
        ctl_wr = 1; ctl_wdata = 0; ev(11);
        chk("R9 event with disable stored", {61'd0, tos}, 64'd3);
        ev(12);
        chk("R9 disabled afterwards", {61'd0, tos}, 64'd3);
        rd(2, "R9 slot2", ent(11));

        phase = "R6";
        ctl(1);
        dbg_exc = 1; ev(13);
        chk("R6 event with freeze stored", {61'd0, tos}, 64'd4);
        phase = "R5";
        ev(14);
        chk("R5 frozen ignores event", {61'd0, tos}, 64'd4);
        rd(4, "R5 slot4 old", ent(5));

        phase = "R7";
        ctl(1); ev(15);
        chk("R7 rewrite 1 keeps freeze", {61'd0, tos}, 64'd4);
        ctl(0); ctl(1); ev(16);
        chk("R7 restart records", {61'd0, tos}, 64'd5);
        rd(3, "R7 history kept", ent(13));
        rd(4, "R7 new entry", ent(16));

        phase = "R8";
        rd_idx = 3'd5; ev(17);
        chk("R8 read before write", rd_data, ent(6));
        rd(5, "R8 read after write", ent(17));

        phase = "RAND";
        for (int i = 0; i < 400; i++) begin
            ctl_wr    = ($urandom_range(0, 15) == 0);
            ctl_wdata = $urandom_range(0, 3) != 0;
            ev_valid  = $urandom_range(0, 1);
            ev_from   = $urandom; ev_to = $urandom;
            dbg_exc   = ($urandom_range(0, 19) == 0);
            rd_idx    = 3'($urandom_range(0, 7));
            step();
        end
        idle();
        step();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait (cyc > 50000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<50000", cyc);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule